// File: doc/BRIEF.md
# Close-Page FCFS DRAM Access Timer

This block is the timing core of a memory controller that serves reads to a multi-rank DRAM device. It takes read requests over a valid/ready stream, each naming a rank, a bank and a transaction tag. It holds them in a short queue and starts them strictly in arrival order. Every access follows the close-page policy. It moves a command over the command bus, opens a row, reads one column, moves one data burst and then precharges the bank. No row stays open for a later access.

An access may start only when the locality rules allow it. A request to the same bank as an earlier access must wait until that bank has finished its row cycle and precharge. This holds even if accesses to other banks came in between. A request to another bank of a rank used recently keeps a precharge-plus-row-to-column distance from the last start in that rank. Any two starts keep at least one data-burst length apart, because all ranks share the data bus. When the data burst of an access ends, the block pulses a completion strobe with the tag and the number of cycles since the request reached the head of the queue.

The request side follows valid/ready rules. A requester holds `req_valid` and its fields steady until it sees `req_ready` high at a clock edge. `req_ready` depends only on queue occupancy and never on `req_valid`. The completion side has no back-pressure: `done` is a one-cycle strobe that must be taken when it appears.

Top module: `dct_timer`

## Requirements
- R1: During and straight after reset, `done` is low and `req_ready` is high.
- R2: A request that reaches the head of an empty, idle block starts in that cycle. Its `done` appears T_CMD+T_RCD+T_CAS+T_BURST cycles later (9 with defaults), with `done_lat` equal to that value.
- R3: Two accesses to the same rank and bank start at least T_RAS+T_RP cycles apart (11 with defaults), and the later start happens as soon as that allows.
- R4: Accesses to different banks of the same rank start at least T_RP+T_RCD cycles apart (6 with defaults).
- R5: Accesses to different ranks start at least T_BURST cycles apart (2 with defaults). No other spacing applies to them.
- R6: The same-bank hold of R3 stays in force when accesses to other banks were started in between.
- R7: Completions come out in request order, each carrying the tag of its request, and never without an outstanding access.
- R8: The queue holds Q_DEPTH requests (4 with defaults). When it is full, `req_ready` is low and a held request is taken later without loss.
- R9: `done` is a single-cycle strobe in the cycle after the data burst ends. `done_lat` counts cycles from the cycle the request became head of the queue up to the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request this cycle |
| req_rank | input | RANK_W (2) | Target rank of the request |
| req_bank | input | BANK_W (2) | Target bank within the rank |
| req_tag | input | TAG_W (4) | Transaction tag returned on completion |
| done | output | 1 | One-cycle completion strobe |
| done_tag | output | TAG_W (4) | Tag of the completed access |
| done_lat | output | LAT_W (8) | Cycles from head of queue to completion |

## Verification
A request accepted in cycle c becomes head in cycle c+1, or one cycle after the previous access started. It starts in the first cycle where the bank, rank and bus distances of R3 to R5 are met. Its strobe is due exactly T_CMD+T_RCD+T_CAS+T_BURST cycles after that start. The driver computes the head cycle, start cycle, completion cycle and latency for every accepted request from these rules and queues them. The monitor samples on the falling edge and compares the tag, the latency and the exact completion cycle against the head of that queue. A strobe that is early, late, repeated or reordered is therefore caught.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // Relation of an access to the access started just before it.
  typedef enum logic [1:0] {
    LOC_FIRST      = 2'd0,
    LOC_OTHER_RANK = 2'd1,
    LOC_SAME_RANK  = 2'd2,
    LOC_SAME_BANK  = 2'd3
  } locality_e;

  function automatic locality_e classify(input logic have_prev,
                                         input logic rank_eq,
                                         input logic bank_eq);
    if (!have_prev)          return LOC_FIRST;
    if (rank_eq && bank_eq)  return LOC_SAME_BANK;
    if (rank_eq)             return LOC_SAME_RANK;
    return LOC_OTHER_RANK;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dct_fifo.sv
module dct_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PTR_W:0]   fill;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (fill != (PTR_W + 1)'(DEPTH));
  assign out_valid = (fill != '0);
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      fill <= fill + {{PTR_W{1'b0}}, push} - {{PTR_W{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/dct_gap_ctr.sv
// Hold-off counter: after a load it reports busy for GAP-1 cycles, so the
// next start it guards can happen GAP cycles after the loading start.
module dct_gap_ctr #(
  parameter int CNT_W = 4,
  parameter int GAP   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  if (GAP <= 1) begin : g_free
    assign busy = 1'b0;
  end else begin : g_count
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (load)           remain <= CNT_W'(GAP - 1);
      else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
  end

endmodule

// File: rtl/dct_flight.sv
// Carries each started access through its command, row, column and burst
// phases; the last stage marks the cycle after the burst ends.
module dct_flight #(
  parameter int STAGES = 9,
  parameter int TAG_W  = 4,
  parameter int LAT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  input  logic [LAT_W-1:0] start_stamp,
  input  logic [LAT_W-1:0] now,
  output logic             fin,
  output logic [TAG_W-1:0] fin_tag,
  output logic [LAT_W-1:0] fin_lat
);
  logic [STAGES-1:0] live;
  logic [TAG_W-1:0]  tag_q   [STAGES];
  logic [LAT_W-1:0]  stamp_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= '0;
    else        live <= {live[STAGES-2:0], start};
  end

  always_ff @(posedge clk) begin
    tag_q[0]   <= start_tag;
    stamp_q[0] <= start_stamp;
    for (int k = 1; k < STAGES; k++) begin
      tag_q[k]   <= tag_q[k-1];
      stamp_q[k] <= stamp_q[k-1];
    end
  end

  assign fin     = live[STAGES-1];
  assign fin_tag = tag_q[STAGES-1];
  assign fin_lat = now - stamp_q[STAGES-1];

endmodule

// File: rtl/dct_timer.sv
module dct_timer
  import dct_pkg::*;
#(
  parameter int N_RANK  = 4,
  parameter int N_BANK  = 4,
  parameter int TAG_W   = 4,
  parameter int LAT_W   = 8,
  parameter int Q_DEPTH = 4,
  parameter int T_CMD   = 1,
  parameter int T_RCD   = 3,
  parameter int T_CAS   = 3,
  parameter int T_RAS   = 8,
  parameter int T_RP    = 3,
  parameter int T_BURST = 2,
  localparam int RANK_W = (N_RANK > 1) ? $clog2(N_RANK) : 1,
  localparam int BANK_W = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RANK_W-1:0] req_rank,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              done,
  output logic [TAG_W-1:0]  done_tag,
  output logic [LAT_W-1:0]  done_lat
);
  localparam int G_BANK   = T_RAS + T_RP;
  localparam int G_RANK   = T_RP + T_RCD;
  localparam int G_BUS    = T_BURST;
  localparam int DATA_LAT = T_CMD + T_RCD + T_CAS + T_BURST;
  localparam int CNT_W    = $clog2(max2(max2(G_BANK, G_RANK), G_BUS) + 1);
  localparam int ENT_W    = RANK_W + BANK_W + TAG_W;

  if (T_RAS < T_RCD + T_CAS + T_BURST) begin : g_bad_ras
    $error("row active time shorter than its row, column and burst phases");
  end
  if (DATA_LAT < 2) begin : g_bad_lat
    $error("data latency must be at least two cycles");
  end

  logic              head_valid, issue, blocked;
  logic [ENT_W-1:0]  head_ent;
  logic [RANK_W-1:0] head_rank;
  logic [BANK_W-1:0] head_bank;
  logic [TAG_W-1:0]  head_tag;

  dct_fifo #(.W(ENT_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req_valid & req_ready),
    .push_data ({req_rank, req_bank, req_tag}),
    .pop       (issue),
    .in_ready  (req_ready),
    .out_valid (head_valid),
    .out_data  (head_ent)
  );

  assign {head_rank, head_bank, head_tag} = head_ent;

  // Hold-off trackers: one per bank, one per rank, one for the data bus.
  logic [N_RANK-1:0][N_BANK-1:0] bank_busy;
  logic [N_RANK-1:0]             rank_busy;
  logic                          bus_busy;

  for (genvar r = 0; r < N_RANK; r++) begin : g_rank
    logic rank_hit;
    assign rank_hit = issue && (head_rank == RANK_W'(r));

    dct_gap_ctr #(.CNT_W(CNT_W), .GAP(G_RANK)) u_rank_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rank_hit),
      .busy  (rank_busy[r])
    );

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      dct_gap_ctr #(.CNT_W(CNT_W), .GAP(G_BANK)) u_bank_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rank_hit && (head_bank == BANK_W'(b))),
        .busy  (bank_busy[r][b])
      );
    end
  end

  dct_gap_ctr #(.CNT_W(CNT_W), .GAP(G_BUS)) u_bus_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (issue),
    .busy  (bus_busy)
  );

  assign blocked = bank_busy[head_rank][head_bank] | rank_busy[head_rank] | bus_busy;
  assign issue   = head_valid & ~blocked;

  // Time stamp of the cycle the current head arrived at the head position.
  logic [LAT_W-1:0] now, stamp_q, head_stamp;
  logic             fresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now     <= '0;
      stamp_q <= '0;
      fresh_q <= 1'b1;
    end else begin
      now     <= now + 1'b1;
      fresh_q <= issue | ~head_valid;
      if (head_valid && fresh_q) stamp_q <= now;
    end
  end

  assign head_stamp = fresh_q ? now : stamp_q;

  dct_flight #(.STAGES(DATA_LAT), .TAG_W(TAG_W), .LAT_W(LAT_W)) u_flight (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (issue),
    .start_tag   (head_tag),
    .start_stamp (head_stamp),
    .now         (now),
    .fin         (done),
    .fin_tag     (done_tag),
    .fin_lat     (done_lat)
  );

endmodule

// File: rtl/dct_timer_chk.sv
module dct_timer_chk
  import dct_pkg::*;
#(
  parameter int RANK_W   = 2,
  parameter int BANK_W   = 2,
  parameter int LAT_W    = 8,
  parameter int Q_DEPTH  = 4,
  parameter int T_RCD    = 3,
  parameter int T_RAS    = 8,
  parameter int T_RP     = 3,
  parameter int T_BURST  = 2,
  parameter int DATA_LAT = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              issue,
  input logic [RANK_W-1:0] issue_rank,
  input logic [BANK_W-1:0] issue_bank,
  input logic              done,
  input logic [LAT_W-1:0]  done_lat
);
  localparam logic [15:0] GAP_BANK = 16'(T_RAS + T_RP);
  localparam logic [15:0] GAP_RANK = 16'(T_RP + T_RCD);
  localparam logic [15:0] GAP_BUS  = 16'(T_BURST);
  localparam logic [15:0] DEPTH16  = 16'(Q_DEPTH);

  logic [15:0]       since, held, outstanding;
  logic [RANK_W-1:0] prev_rank;
  logic [BANK_W-1:0] prev_bank;
  logic              have_prev;
  locality_e         loc;

  assign loc = classify(have_prev, issue_rank == prev_rank, issue_bank == prev_bank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since       <= '0;
      held        <= '0;
      outstanding <= '0;
      prev_rank   <= '0;
      prev_bank   <= '0;
      have_prev   <= 1'b0;
    end else begin
      held        <= held + 16'(req_valid && req_ready) - 16'(issue);
      outstanding <= outstanding + 16'(issue) - 16'(done);
      if (issue) begin
        since     <= 16'd1;
        prev_rank <= issue_rank;
        prev_bank <= issue_bank;
        have_prev <= 1'b1;
      end else if (since != 16'hFFFF) begin
        since <= since + 16'd1;
      end
    end
  end

  AST_BANK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    issue && loc == LOC_SAME_BANK |-> since >= GAP_BANK);  // R3
  AST_RANK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    issue && loc == LOC_SAME_RANK |-> since >= GAP_RANK);  // R4
  AST_BUS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    issue && loc != LOC_FIRST |-> since >= GAP_BUS);  // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    held <= DEPTH16);  // R8
  AST_DONE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> outstanding != 16'd0);  // R7
  AST_MIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_lat >= LAT_W'(DATA_LAT));  // R2

endmodule

bind dct_timer dct_timer_chk #(
  .RANK_W   (RANK_W),
  .BANK_W   (BANK_W),
  .LAT_W    (LAT_W),
  .Q_DEPTH  (Q_DEPTH),
  .T_RCD    (T_RCD),
  .T_RAS    (T_RAS),
  .T_RP     (T_RP),
  .T_BURST  (T_BURST),
  .DATA_LAT (DATA_LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .issue      (issue),
  .issue_rank (head_rank),
  .issue_bank (head_bank),
  .done       (done),
  .done_lat   (done_lat)
);

// File: tb/dct_timer_bench.sv
module dct_timer_bench;
  localparam int CLK_NS   = 10;
  localparam int T_CMD    = 1;
  localparam int T_RCD    = 3;
  localparam int T_CAS    = 3;
  localparam int T_RAS    = 8;
  localparam int T_RP     = 3;
  localparam int T_BURST  = 2;
  localparam int GB       = T_RAS + T_RP;
  localparam int GR       = T_RP + T_RCD;
  localparam int GD       = T_BURST;
  localparam int DLAT     = T_CMD + T_RCD + T_CAS + T_BURST;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready;
  logic [1:0] req_rank, req_bank;
  logic [3:0] req_tag;
  logic       done;
  logic [3:0] done_tag;
  logic [7:0] done_lat;

  always #(CLK_NS / 2) clk = ~clk;

  dct_timer u_dct_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_rank  (req_rank),
    .req_bank  (req_bank),
    .req_tag   (req_tag),
    .done      (done),
    .done_tag  (done_tag),
    .done_lat  (done_lat)
  );

  typedef struct {
    int    tag;
    int    lat;
    int    at;
    string req;
  } exp_t;

  exp_t expq[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  int   next_tag = 0;
  int   stalls = 0;
  int   bank_last [4][4];
  int   rank_last [4];
  int   prev_start = -1000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: offers one request, waits for acceptance, predicts its result.
  task automatic send(input int r, input int b, input string req);
    int p, head, st;
    exp_t e;
    req_valid = 1'b1;
    req_rank  = 2'(r);
    req_bank  = 2'(b);
    req_tag   = 4'(next_tag);
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
    end
    p    = cyc;
    head = (p + 1 > prev_start + 1) ? p + 1 : prev_start + 1;
    st   = head;
    if (bank_last[r][b] + GB > st) st = bank_last[r][b] + GB;
    if (rank_last[r] + GR > st)    st = rank_last[r] + GR;
    if (prev_start + GD > st)      st = prev_start + GD;
    bank_last[r][b] = st;
    rank_last[r]    = st;
    prev_start      = st;
    e.tag = next_tag;
    e.lat = st + DLAT - head;
    e.at  = st + DLAT;
    e.req = req;
    expq.push_back(e);
    next_tag = (next_tag + 1) % 16;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares every completion with the oldest prediction.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R7", "completion with nothing outstanding", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(int'(done_tag) == e.tag, "R7", "tag order", int'(done_tag), e.tag);
        chk(int'(done_lat) == e.lat, e.req, "latency", int'(done_lat), e.lat);
        chk(cyc == e.at, "R9", "completion cycle", cyc, e.at);
      end
    end
  end

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", expq.size(), 0);
    summary();
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) begin
      rank_last[r] = -1000;
      for (int b = 0; b < 4; b++) bank_last[r][b] = -1000;
    end
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_rank  = '0;
    req_bank  = '0;
    req_tag   = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);

    // R2: lone access on an idle block
    send(0, 0, "R2");
    idle(30);

    // R3: back-to-back on one bank
    send(1, 2, "R2");
    send(1, 2, "R3");
    idle(40);

    // R4: two banks of one rank
    send(2, 0, "R4");
    send(2, 1, "R4");
    idle(40);

    // R5: spread over ranks
    send(0, 1, "R5");
    send(3, 1, "R5");
    send(1, 3, "R5");
    idle(40);

    // R6: same bank again after other banks in between
    send(0, 3, "R6");
    send(1, 0, "R6");
    send(2, 2, "R6");
    send(0, 3, "R6");
    idle(40);

    // R8: fill the queue on one bank so back-pressure appears
    stalls = 0;
    for (int i = 0; i < 7; i++) send(3, 3, "R8");
    chk(stalls > 0, "R8", "ready dropped while queue full", stalls, 1);

    for (int i = 0; i < 500 && expq.size() != 0; i++) @(negedge clk);
    idle(5);
    chk(expq.size() == 0, "R7", "all completions seen", expq.size(), 0);
    summary();
    $finish;
  end

endmodule